// File: doc/BRIEF.md
# Double-Buffered Column Data Streamer

The block sends one column's grayscale frame to a chain of LED driver chips over a transmit-only serial link. Two byte-wide buffers, each one frame deep, are kept inside the block. A host write port fills them at any time. A scan sequencer tells the block which column has just become active and pulses a start strobe. The block then sends the buffer of the *other* column, which is the column that will be lit next. The data shifted in now is therefore latched and shown at the following scan event.

A frame is 144 bytes: 24 bytes per driver chip, three chips per board (one for each of red, green and blue), and two boards. Bytes leave in address order from address 0 and are sent once each, most significant bit first. The serial clock runs at one eighth of the system clock, idles low, and the receiver captures data on its rising edge. The block raises a busy flag for the whole frame and emits a one-cycle done pulse at the end.

Top module: `col_streamer`

## Requirements
- R1: After reset, sclk_o, mosi_o, busy_o and done_o are all low.
- R2: sclk_o is low whenever busy_o is low. During a frame each bit lasts 8 system clocks: sclk_o is low for the first 4 and high for the last 4.
- R3: mosi_o changes only while sclk_o is low, so it is stable at every rising edge of sclk_o. Each byte is sent with bit 7 first and bit 0 last.
- R4: A frame carries exactly 144 bytes, which is 1152 rising edges of sclk_o. The bytes are taken from addresses 0, 1, …, 143 of the chosen buffer, each address once.
- R5: If col_i is 0 when the strobe is accepted, buffer 1 (wr_buf_i = 1) is sent. If col_i is 1, buffer 0 is sent.
- R6: start_i is accepted only while busy_o is low. A strobe that arrives while busy has no effect on the running frame and does not start another frame.
- R7: busy_o rises in the cycle after an accepted strobe. It stays high for 9216 cycles and falls together with the last falling edge of sclk_o.
- R8: done_o is a single-cycle pulse. It is high in the first cycle in which busy_o is low again after a frame, and there is one pulse per frame.
- R9: After a frame, sclk_o stays low and mosi_o keeps the last bit sent (bit 0 of byte 143) until the next frame starts.
- R10: A host write (wr_en_i, wr_buf_i, wr_addr_i in 0 to 143) updates the addressed byte in the following cycle and may happen at any time. A write to a byte of the sending buffer that has not yet been loaded is sent with the new value. A write to the other buffer leaves the running frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write enable |
| wr_buf_i | input | 1 | Buffer targeted by the host write |
| wr_addr_i | input | 8 | Byte address of the host write, 0 to 143 |
| wr_data_i | input | 8 | Byte written |
| start_i | input | 1 | Start strobe from the scan sequencer |
| col_i | input | 1 | Column the sequencer has just switched to |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data, MSB first |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong bit or phase counter shows at once as a clock high or low for the wrong number of cycles. Over a whole frame it shows as a rising-edge count other than 1152, or as busy falling at the wrong cycle, all within one frame of 9216 cycles. A byte index or shift register that goes wrong shows as a mismatched MOSI bit at the first affected bit time. A buffer select latched the wrong way round sends the other column's bytes and is caught on the first byte whose two buffer values differ. Every output is compared with a reference model on every clock, so the first wrong cycle is reported where it happens.

// File: rtl/streamer_pkg.sv
package streamer_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} seq_state_e;
endpackage

// File: rtl/col_buf_pair.sv
module col_buf_pair
  import streamer_pkg::*;
#(
  parameter int unsigned DEPTH = 144,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_buf_i,
  input  logic [AW-1:0] wr_addr_i,
  input  byte_t         wr_data_i,
  input  logic          rd_buf_i,
  input  logic [AW-1:0] rd_addr_i,
  output byte_t         rd_data_o
);
  byte_t rd_bank [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    byte_t mem_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en_i && (wr_buf_i == b[0]) && (32'(wr_addr_i) < DEPTH)) begin
        mem_q[wr_addr_i] <= wr_data_i;
      end
    end
    assign rd_bank[b] = (32'(rd_addr_i) < DEPTH) ? mem_q[rd_addr_i] : '0;
  end

  assign rd_data_o = rd_bank[rd_buf_i];
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int unsigned DIV = 8,
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1,
  localparam int unsigned HALF = DIV / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_hi_o,
  output logic bit_end_o
);
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ph_q <= '0;
    else if (!run_i || bit_end_o) ph_q <= '0;
    else                          ph_q <= ph_q + 1'b1;
  end

  assign bit_end_o = run_i && (ph_q == PW'(DIV - 1));
  assign sclk_hi_o = run_i && (ph_q >= PW'(HALF));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import streamer_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 144,
  localparam int unsigned AW = $clog2(FRAME_BYTES),
  localparam int unsigned BCW = $clog2(BYTE_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          col_i,
  input  logic          bit_end_i,
  input  byte_t         rd_data_i,
  output logic          rd_buf_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          run_o,
  output logic          mosi_o,
  output logic          done_o
);
  seq_state_e     state_q;
  logic [BCW-1:0] bit_q;
  logic [AW-1:0]  idx_q;
  byte_t          sh_q;
  logic           sel_q;
  logic           done_q;

  logic accept, last_bit, last_byte;
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign last_bit  = bit_end_i && (bit_q == BCW'(BYTE_W - 1));
  assign last_byte = idx_q == AW'(FRAME_BYTES - 1);

  // next column's buffer is the opposite of the one just selected
  assign rd_buf_o  = (state_q == ST_SHIFT) ? sel_q : ~col_i;
  assign rd_addr_o = (state_q == ST_SHIFT) ? idx_q + 1'b1 : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      sel_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_SHIFT;
        bit_q   <= '0;
        idx_q   <= '0;
        sel_q   <= ~col_i;
        sh_q    <= rd_data_i;
      end else if (state_q == ST_SHIFT && bit_end_i) begin
        if (last_bit) begin
          if (last_byte) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            bit_q <= '0;
            sh_q  <= rd_data_i;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign run_o  = state_q == ST_SHIFT;
  assign mosi_o = sh_q[BYTE_W-1];
  assign done_o = done_q;
endmodule

// File: rtl/col_streamer.sv
module col_streamer
  import streamer_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 144,
  parameter int unsigned CLK_DIV = 8,
  localparam int unsigned AW = $clog2(FRAME_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_buf_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          start_i,
  input  logic          col_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          busy_o,
  output logic          done_o
);
  logic          rd_buf, run, bit_end, sclk_hi;
  logic [AW-1:0] rd_addr;
  byte_t         rd_data;

  col_buf_pair #(.DEPTH(FRAME_BYTES)) u_bufs (
    .clk_i, .rst_ni, .wr_en_i, .wr_buf_i, .wr_addr_i, .wr_data_i,
    .rd_buf_i(rd_buf), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  bit_timer #(.DIV(CLK_DIV)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .sclk_hi_o(sclk_hi), .bit_end_o(bit_end)
  );

  frame_seq #(.FRAME_BYTES(FRAME_BYTES)) u_seq (
    .clk_i, .rst_ni, .start_i, .col_i, .bit_end_i(bit_end), .rd_data_i(rd_data),
    .rd_buf_o(rd_buf), .rd_addr_o(rd_addr), .run_o(run), .mosi_o, .done_o
  );

  assign sclk_o = sclk_hi;
  assign busy_o = run;
endmodule

// File: rtl/col_streamer_chk.sv
module col_streamer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sclk_o,
  input logic mosi_o,
  input logic busy_o,
  input logic done_o
);
  assert_idle_clk_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);

  assert_data_stable_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  assert_busy_from_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_end_clk_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !sclk_o);
endmodule

bind col_streamer col_streamer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sclk_o(sclk_o),
  .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_col_streamer.sv
module tb_col_streamer;
  localparam int NB = 144;
  localparam int FRAME_CYC = NB * 64;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_buf = 0, start = 0, col = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic sclk, mosi, busy, done;

  always #2 clk = ~clk;

  col_streamer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_buf_i(wr_buf),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .start_i(start), .col_i(col),
    .sclk_o(sclk), .mosi_o(mosi), .busy_o(busy), .done_o(done)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] mm [2][NB];
  bit m_busy, m_done, m_sel;
  int m_cnt;
  logic [7:0] m_byte;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_sel = 0; m_cnt = 0; m_byte = 0;
      for (int b = 0; b < 2; b++) for (int i = 0; i < NB; i++) mm[b][i] = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt == FRAME_CYC - 1) begin
          m_busy = 0; m_done = 1;
        end else begin
          m_cnt++;
          if (m_cnt % 64 == 0) m_byte = mm[m_sel][m_cnt / 64];
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_sel = ~col; m_byte = mm[~col][0];
      end
      if (wr_en && wr_addr < NB) mm[wr_buf][wr_addr] = wr_data;
    end
  end

  // per-cycle comparison and serial receiver
  bit prev_sclk = 0;
  logic [7:0] rx_sh;
  int rx_bits = 0, done_cnt = 0;
  logic [7:0] rx_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_sclk, e_mosi;
      e_sclk = m_busy && ((m_cnt % 8) >= 4);
      e_mosi = m_byte[7 - ((m_cnt / 8) % 8)];
      chk(sclk === e_sclk, "R2 sclk", sclk, e_sclk);
      chk(mosi === e_mosi, "R3 mosi", mosi, e_mosi);
      chk(busy === m_busy, "R7 busy", busy, m_busy);
      chk(done === m_done, "R8 done", done, m_done);
      if (sclk && !prev_sclk) begin
        rx_sh = {rx_sh[6:0], mosi};
        rx_bits++;
        if (rx_bits % 8 == 0) rx_q.push_back(rx_sh);
      end
      if (done) done_cnt++;
      prev_sclk = sclk;
    end
  end

  task automatic host_wr(input bit b, input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_buf = b; wr_addr = 8'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic strobe(input bit c);
    @(negedge clk);
    start = 1; col = c;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_frame(input bit b, input string tag);
    chk(rx_q.size() == NB, "R4 byte count", rx_q.size(), NB);
    for (int i = 0; i < NB && i < rx_q.size(); i++)
      chk(rx_q[i] === mm[b][i], tag, rx_q[i], mm[b][i]);
    rx_q.delete();
    rx_bits = 0;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    #1;
    chk(sclk === 0 && mosi === 0, "R1 reset serial", {sclk, mosi}, 0);
    chk(busy === 0 && done === 0, "R1 reset flags", {busy, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NB; i++) host_wr(0, i, 8'(i * 7 + 3));
    for (int i = 0; i < NB; i++) host_wr(1, i, 8'((i * 29) ^ 8'hA5));
    host_wr(1, 200, 8'hFF); // out of range, ignored

    // R5: column 0 selected -> buffer 1; R6: strobe while busy ignored
    strobe(0);
    repeat (500) @(negedge clk);
    strobe(1);
    wait_done();
    @(negedge clk);
    chk(done_cnt == 1, "R6 one frame", done_cnt, 1);
    check_frame(1, "R5 col0 sends buf1");
    chk(mosi === mm[1][NB-1][0], "R9 mosi holds last bit", mosi, mm[1][NB-1][0]);
    chk(sclk === 0, "R9 sclk low after frame", sclk, 0);
    repeat (20) @(negedge clk);
    chk(!busy && !done, "R8 idle after pulse", {busy, done}, 0);

    // R10: writes during frame
    strobe(1);
    host_wr(0, 140, 8'h3C);
    host_wr(1, 5, 8'h77);
    wait_done();
    @(negedge clk);
    chk(done_cnt == 2, "R8 pulse per frame", done_cnt, 2);
    chk(mm[0][140] == 8'h3C, "R10 bench model", mm[0][140], 8'h3C);
    check_frame(0, "R10 col1 sends buf0 with late write");

    // back-to-back frame, R5 again
    strobe(0);
    wait_done();
    @(negedge clk);
    check_frame(1, "R5 buf1 after other-buffer write");
    chk(done_cnt == 3, "R4 frames complete", done_cnt, 3);
    report();
  end
endmodule